// File: doc/BRIEF.md
# DMA Address Translation Walker

This block turns a device DMA input address into a physical address. It walks a radix page table held in memory. A request carries the input address, the root table pointer, a 3-bit width code and a write flag. The width code sets the width of input address the tables cover and how many levels the walk has, from 2 levels to 6 levels. The block then reads one 64-bit table entry per level through a simple memory port that has a request side and a response side. The result is either the translated address or a fault with a reason code.

Only one request is handled at a time. The control is a four-state machine:
- **IDLE**: the block waits for a request. It leaves through *accept-walk* to ISSUE, or through *accept-reject* to DONE when the width code or the address range is bad.
- **ISSUE**: the block presents an entry read. It moves to WAIT through *read-taken* when the memory accepts the read.
- **WAIT**: the block waits for the entry data. It goes back to ISSUE through *descend* when there is another level to read. It moves to DONE through *leaf-or-fault* on the last level or on a failed entry.
- **DONE**: the block holds the result. It returns to IDLE through *consumed* when the consumer takes the result.

A small separate helper rounds a guest address width up to the next width the table layout supports.

Top module: `dma_xlate_walker`

## Requirements
- R1: On success, bits [11:0] of the result equal bits [11:0] of the input address. The upper bits come from the final entry.
- R2: Each entry read address is the current table base with bits [11:0] cleared, ORed with the 9-bit level index shifted left by 3. The walk starts at the top level and takes each level's index from input address bits [12+9*(L-1) +: 9]. Levels are numbered from the top (L = level count) down to 1.
- R3: For width code c in 0..4, the block covers min(30+9c, 64) address bits. A successful walk makes exactly c+2 entry reads.
- R4: Width codes 5, 6 and 7 end with fault=1 and reason=1, reported level 0, and no memory read.
- R5: An input address with any bit set at or above the covered width ends with fault=1 and reason=2, reported level 0, and no memory read.
- R6: An entry with bit 0 (read allowed) and bit 1 (write allowed) both clear ends the walk with fault=1 and reason=3. The reported level is the level of that entry.
- R7: For a write request, an entry with bit 1 clear ends the walk with fault=1 and reason=4 at that entry's level. The same table read by a non-write request succeeds. A success reports fault=0, reason=0 and level 0.
- R8: The result stays valid and unchanged until rsp_ready is high at a clock edge.
- R9: req_ready is low from the cycle after a request is accepted until the cycle after its result is consumed.
- R10: The next table base and the final page frame take entry bits [PHYS_W-1:12] only. PHYS_W defaults to 52, and entry bits above it are dropped.
- R11: For a guest width g in 12..64, agaw_out = g when (g-12) mod 9 = 0. Otherwise agaw_out = g+9-((g-12) mod 9). In both cases the value is capped at 64.
- R12: A pending entry read keeps its valid and its address unchanged until the memory accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A translation request is present |
| req_ready | output | 1 | The block can accept a request |
| req_iova | input | 64 | Input address to translate |
| req_root | input | 64 | Root table pointer |
| req_wcode | input | 3 | Width code |
| req_write | input | 1 | The request is a write access |
| mem_req_valid | output | 1 | An entry read is requested |
| mem_req_ready | input | 1 | The memory accepts the entry read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data is returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | The result is present |
| rsp_ready | input | 1 | The consumer takes the result |
| rsp_fault | output | 1 | The translation failed |
| rsp_reason | output | 3 | 0 ok, 1 bad width code, 2 out of range, 3 not present, 4 write denied |
| rsp_level | output | 3 | Level of the failing entry, 0 otherwise |
| rsp_pa | output | 64 | Translated physical address (0 on a fault) |
| gaw_in | input | 7 | Guest width for the rounding helper |
| agaw_out | output | 7 | Rounded adjusted width |

## Verification
The bench aims at the level index slices near the top of wide walks. Getting these wrong would send the 6-level walk, with its top index cut off above bit 63, or the 5-level walk, with bit 56 set, to the wrong entry address. It also aims at the early rejects. A design that checked the range too loosely, or read memory before rejecting, would show a memory read or a success where a reason 1 or reason 2 fault is due. Further cases cover a missing entry in the middle of the walk, a write-denied entry that a read still passes, and page frames with junk above the physical width. A design that gets these wrong reports the wrong level, denies reads, or leaks high bits into the result. A result held under back-pressure and a sweep of the rounding helper across values on and off the 9-bit stride complete the set.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int XW_STRIDE = 9;
    localparam int XW_PAGE   = 12;
    localparam int XW_BASE_W = 30;
    localparam int XW_MAX_W  = 64;
    localparam int XW_CODES  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } xw_state_e;

    typedef enum logic [2:0] {
        RSN_OK     = 3'd0,
        RSN_BADW   = 3'd1,
        RSN_RANGE  = 3'd2,
        RSN_ABSENT = 3'd3,
        RSN_WRDENY = 3'd4
    } xw_reason_e;
endpackage

// File: rtl/xw_width_dec.sv
module xw_width_dec
    import xw_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [2:0]    code,
    input  logic [AW-1:0] iova,
    output logic          code_ok,
    output logic [2:0]    levels,
    output logic          range_bad
);
    logic [6:0] width_raw;
    logic [6:0] width;

    always_comb begin
        code_ok   = (int'(code) < XW_CODES);
        levels    = code + 3'd2;
        width_raw = 7'(XW_BASE_W) + 7'(XW_STRIDE) * {4'b0, code};
        width     = (width_raw > 7'(XW_MAX_W)) ? 7'(XW_MAX_W) : width_raw;
        range_bad = 1'b0;
        for (int i = 0; i < AW; i++) begin
            if (i >= int'(width) && iova[i]) range_bad = 1'b1;
        end
    end
endmodule

// File: rtl/xw_entry_addr.sv
module xw_entry_addr
    import xw_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] iova,
    input  logic [2:0]    level,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] PAGE_MASK = ~AW'((1 << XW_PAGE) - 1);
    localparam logic [AW-1:0] IDX_MASK  = AW'((1 << XW_STRIDE) - 1);

    logic [6:0]           shamt;
    logic [XW_STRIDE-1:0] idx;

    always_comb begin
        shamt = 7'(XW_PAGE) + 7'(XW_STRIDE) * ({4'b0, level} - 7'd1);
        idx   = XW_STRIDE'((iova >> shamt) & IDX_MASK);
        addr  = (base & PAGE_MASK) | {{(AW-XW_STRIDE-3){1'b0}}, idx, 3'b000};
    end
endmodule

// File: rtl/xw_gaw_round.sv
module xw_gaw_round
    import xw_pkg::*;
(
    input  logic [6:0] gaw,
    output logic [6:0] agaw
);
    int g;
    int rem;
    int adj;

    always_comb begin
        g    = int'(gaw);
        rem  = (g - XW_PAGE) % XW_STRIDE;
        adj  = (rem == 0) ? g : g + XW_STRIDE - rem;
        if (adj > XW_MAX_W) adj = XW_MAX_W;
        agaw = 7'(adj);
    end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import xw_pkg::*;
#(
    parameter int PHYS_W = 52
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_iova,
    input  logic [63:0] req_root,
    input  logic [2:0]  req_wcode,
    input  logic        req_write,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [63:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic        rsp_fault,
    output logic [2:0]  rsp_reason,
    output logic [2:0]  rsp_level,
    output logic [63:0] rsp_pa,
    input  logic [6:0]  gaw_in,
    output logic [6:0]  agaw_out
);
    localparam int          AW         = 64;
    localparam logic [63:0] LOW_MASK   = 64'((1 << XW_PAGE) - 1);
    localparam logic [63:0] FRAME_MASK = ((64'd1 << PHYS_W) - 64'd1) & ~LOW_MASK;

    xw_state_e   state, state_nx;
    logic [63:0] iova_q, base_q, pa_q;
    logic [2:0]  lvl_q, flvl_q;
    logic        wr_q, fault_q;
    xw_reason_e  reason_q;

    logic        code_ok, range_bad;
    logic [2:0]  levels;
    logic [63:0] ent_addr, ent_next;
    logic        ent_absent, ent_wdeny, ent_last;

    xw_width_dec #(.AW(AW)) u_wdec (
        .code      (req_wcode),
        .iova      (req_iova),
        .code_ok   (code_ok),
        .levels    (levels),
        .range_bad (range_bad)
    );

    xw_entry_addr #(.AW(AW)) u_eaddr (
        .base  (base_q),
        .iova  (iova_q),
        .level (lvl_q),
        .addr  (ent_addr)
    );

    xw_gaw_round u_round (
        .gaw  (gaw_in),
        .agaw (agaw_out)
    );

    always_comb begin
        ent_absent = ~mem_rsp_data[0] & ~mem_rsp_data[1];
        ent_wdeny  = wr_q & ~mem_rsp_data[1];
        ent_last   = (lvl_q == 3'd1);
        ent_next   = mem_rsp_data & FRAME_MASK;
    end

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid)
                          state_nx = (code_ok && !range_bad) ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)
                          state_nx = (ent_absent || ent_wdeny || ent_last) ? ST_DONE : ST_ISSUE;
            ST_DONE:  if (rsp_ready) state_nx = ST_IDLE;
        endcase
    end

    // state register and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            iova_q   <= '0;
            base_q   <= '0;
            pa_q     <= '0;
            lvl_q    <= '0;
            flvl_q   <= '0;
            wr_q     <= 1'b0;
            fault_q  <= 1'b0;
            reason_q <= RSN_OK;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    iova_q <= req_iova;
                    base_q <= req_root & ~LOW_MASK;
                    lvl_q  <= levels;
                    wr_q   <= req_write;
                    flvl_q <= '0;
                    pa_q   <= '0;
                    if (!code_ok) begin
                        fault_q  <= 1'b1;
                        reason_q <= RSN_BADW;
                    end else if (range_bad) begin
                        fault_q  <= 1'b1;
                        reason_q <= RSN_RANGE;
                    end else begin
                        fault_q  <= 1'b0;
                        reason_q <= RSN_OK;
                    end
                end
                ST_ISSUE: ;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (ent_absent) begin
                        fault_q  <= 1'b1;
                        reason_q <= RSN_ABSENT;
                        flvl_q   <= lvl_q;
                    end else if (ent_wdeny) begin
                        fault_q  <= 1'b1;
                        reason_q <= RSN_WRDENY;
                        flvl_q   <= lvl_q;
                    end else if (ent_last) begin
                        pa_q <= ent_next | (iova_q & LOW_MASK);
                    end else begin
                        base_q <= ent_next;
                        lvl_q  <= lvl_q - 3'd1;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_ISSUE);
        mem_req_addr  = ent_addr;
        rsp_valid     = (state == ST_DONE);
        rsp_fault     = fault_q;
        rsp_reason    = reason_q;
        rsp_level     = flvl_q;
        rsp_pa        = pa_q;
    end
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_iova,
    input logic [2:0]  req_wcode,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic        rsp_fault,
    input logic [2:0]  rsp_reason,
    input logic [2:0]  rsp_level,
    input logic [63:0] rsp_pa,
    input logic [6:0]  gaw_in,
    input logic [6:0]  agaw_out
);
    logic [11:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_iova[11:0];
    end

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_pa[11:0] == off_q);

    a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    a_r4_badcode_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_wcode > 3'd4 |=> rsp_valid && rsp_reason == 3'd1 && !mem_req_valid);

    a_r6_absent_level: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_reason == 3'd3 |-> rsp_fault && rsp_level != 3'd0);

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_reason) && $stable(rsp_level));

    a_r9_busy_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r9_busy_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r11_round_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
        gaw_in >= 7'd12 && gaw_in <= 7'd64 |->
        agaw_out >= gaw_in && agaw_out <= 7'd64 && (agaw_out == 7'd64 || (agaw_out - 7'd12) % 7'd9 == 7'd0));

    a_r12_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind dma_xlate_walker xw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_iova      (req_iova),
    .req_wcode     (req_wcode),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_reason    (rsp_reason),
    .rsp_level     (rsp_level),
    .rsp_pa        (rsp_pa),
    .gaw_in        (gaw_in),
    .agaw_out      (agaw_out)
);

// File: tb/dma_xlate_walker_test.sv
`timescale 1ns/1ps
module dma_xlate_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_iova = '0;
    logic [63:0] req_root = '0;
    logic [2:0]  req_wcode = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [2:0]  rsp_reason;
    logic [2:0]  rsp_level;
    logic [63:0] rsp_pa;
    logic [6:0]  gaw_in = 7'd30;
    logic [6:0]  agaw_out;

    always #2.5 clk = ~clk;

    dma_xlate_walker uut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit busy = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_addr_q[$];
    logic [63:0] next_tab = 64'h0000_0000_0010_0000;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] idx_addr(input logic [63:0] base, input logic [63:0] iova, input int lvl);
        logic [63:0] idx = (iova >> (12 + 9 * (lvl - 1))) & 64'h1FF;
        return (base & ~64'hFFF) + idx * 8;
    endfunction

    // behavioural reference: expected reads and result
    task automatic model(input logic [63:0] iova, root, input logic [2:0] code, input logic wr,
                         output logic [63:0] fault, reason, level, pa);
        int w;
        logic [63:0] base, e, a;
        exp_addr_q.delete();
        fault = 1; level = 0; pa = 0;
        if (code > 3'd4) begin reason = 1; return; end
        w = 30 + 9 * int'(code);
        if (w > 64) w = 64;
        if (w < 64 && (iova >> w) != 0) begin reason = 2; return; end
        base = root;
        for (int l = int'(code) + 2; l >= 1; l--) begin
            a = idx_addr(base, iova, l);
            exp_addr_q.push_back(a);
            e = rd(a);
            if (e[1:0] == 2'b00) begin reason = 3; level = 64'(l); return; end
            if (wr && !e[1]) begin reason = 4; level = 64'(l); return; end
            base = e & ((64'd1 << 52) - 1) & ~64'hFFF;
        end
        fault = 0; reason = 0;
        pa = base | (iova & 64'hFFF);
    endtask

    // lays out a fresh chain of tables for one address
    task automatic build(input logic [63:0] root, iova, input int code, input logic [63:0] leaf,
                         input int absent_lvl, input int nowr_lvl);
        logic [63:0] base = root, e, a;
        logic [1:0] perm;
        for (int l = code + 2; l >= 1; l--) begin
            a = idx_addr(base, iova, l);
            if (l == 1) e = leaf;
            else begin e = next_tab; next_tab += 64'h1000; end
            perm = 2'b11;
            if (l == absent_lvl) perm = 2'b00;
            if (l == nowr_lvl) perm = 2'b01;
            mem[a] = e | {62'b0, perm};
            base = e;
        end
    endtask

    task automatic do_req(input string tag, input logic [63:0] iova, root, input logic [2:0] code,
                          input logic wr, input int hold);
        logic [63:0] ef, er, el, ep;
        logic [63:0] pa0, r0;
        @(negedge clk);
        chk({tag, " R9 idle ready"}, 64'(req_ready), 64'd1);
        model(iova, root, code, wr, ef, er, el, ep);
        req_iova = iova; req_root = root; req_wcode = code; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        pa0 = rsp_pa; r0 = 64'(rsp_reason);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk({tag, " R8 valid held"}, 64'(rsp_valid), 64'd1);
            chk({tag, " R8 pa held"}, rsp_pa, pa0);
            chk({tag, " R8 reason held"}, 64'(rsp_reason), r0);
            chk({tag, " R9 busy ready low"}, 64'(req_ready), 64'd0);
        end
        chk({tag, " fault"}, 64'(rsp_fault), ef);
        chk({tag, " reason R4 R5 R6 R7"}, 64'(rsp_reason), er);
        chk({tag, " level R6"}, 64'(rsp_level), el);
        chk({tag, " pa R1 R10"}, rsp_pa, ep);
        chk({tag, " R3 all reads made"}, 64'(exp_addr_q.size()), 64'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    // memory responder and per-cycle busy model
    initial begin
        int mwait = 0;
        int lat = 0;
        int rdy = 0;
        logic [63:0] cap = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(posedge clk);
            if (req_valid && req_ready) busy <= 1'b1;
            if (rsp_valid && rsp_ready) busy <= 1'b0;
            if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (exp_addr_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4 R5 unexpected read actual=%h expected=none", mem_req_addr);
                end else chk("R2 entry address", mem_req_addr, exp_addr_q.pop_front());
                cap = mem_req_addr;
                mwait = 1 + (lat % 3);
                lat++;
            end else if (mwait > 1) mwait--;
            else if (mwait == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(cap);
                mwait = 0;
            end
            rdy++;
            mem_req_ready <= (rdy % 3 != 0);
        end
    end

    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            chk("R9 ready tracks busy", 64'(req_ready), 64'(!busy));
        end
    end

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    function automatic int ref_round(input int g);
        int r = (g - 12) % 9;
        int a = (r == 0) ? g : g + 9 - r;
        return (a > 64) ? 64 : a;
    endfunction

    initial begin
        logic [63:0] r0 = 64'h0000_0000_0800_0000;
        repeat (3) @(negedge clk);
        chk("reset R9 ready", 64'(req_ready), 64'd1);
        chk("reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("reset R12 mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        build(r0, 64'h0000_0000_3A5C_7123, 0, 64'h000A_BCDE_F000, 0, 0);
        do_req("two-level R3", 64'h0000_0000_3A5C_7123, r0, 3'd0, 1'b0, 0);

        build(r0 + 64'h1000, 64'h0000_8765_4321_0ABC, 2, 64'h0000_0123_4567_8000, 0, 0);
        do_req("four-level write R3", 64'h0000_8765_4321_0ABC, r0 + 64'h1000, 3'd2, 1'b1, 0);

        build(r0 + 64'h2000, 64'hFEDC_BA98_7654_3210, 4, 64'h0000_0FED_CBA9_8000, 0, 0);
        do_req("six-level R2", 64'hFEDC_BA98_7654_3210, r0 + 64'h2000, 3'd4, 1'b0, 0);

        build(r0 + 64'h3000, 64'h01FF_FFFF_FFFF_FFFF, 3, 64'h0000_0001_1111_1000, 0, 0);
        do_req("five-level top bit R5", 64'h01FF_FFFF_FFFF_FFFF, r0 + 64'h3000, 3'd3, 1'b0, 0);

        do_req("code5 R4", 64'h0000_0000_0000_1000, r0, 3'd5, 1'b0, 0);
        do_req("code7 R4", 64'h0000_0000_0000_1000, r0, 3'd7, 1'b0, 0);
        do_req("bit39 code1 R5", 64'h0000_0080_0000_0000, r0, 3'd1, 1'b0, 0);
        do_req("bit30 code0 R5", 64'h0000_0000_4000_0000, r0, 3'd0, 1'b0, 0);

        build(r0 + 64'h4000, 64'h0000_1234_5678_9000, 2, 64'h0000_0000_5555_5000, 2, 0);
        do_req("absent level2 R6", 64'h0000_1234_5678_9000, r0 + 64'h4000, 3'd2, 1'b0, 0);

        build(r0 + 64'h5000, 64'h0000_2222_3333_4444, 2, 64'h0000_0000_7777_7000, 0, 3);
        do_req("write denied R7", 64'h0000_2222_3333_4444, r0 + 64'h5000, 3'd2, 1'b1, 0);
        do_req("read passes R7", 64'h0000_2222_3333_4444, r0 + 64'h5000, 3'd2, 1'b0, 0);

        build(r0 + 64'h6000, 64'h0000_0000_1234_5FED, 0, 64'hFFF0_0012_3456_7000, 0, 0);
        do_req("high bits masked R10", 64'h0000_0000_1234_5FED, r0 + 64'h6000, 3'd0, 1'b0, 4);

        for (int g = 12; g <= 64; g += 3) begin
            @(negedge clk);
            gaw_in = 7'(g);
            #1;
            chk($sformatf("R11 round %0d", g), 64'(agaw_out), 64'(ref_round(g)));
        end
        @(negedge clk);
        report();
    end
endmodule